// File: doc/BRIEF.md
# Lock-Protected Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster. A pixel counter steps down by one every clock from a programmed pixel total to zero and then reloads; each reload of the pixel counter steps a line counter, which also counts down from its own total to zero and reloads. Sync, blank, active-video and clock-gate outputs come from window registers. Each window register holds a start count and a stop count, and the output is decoded by comparing the window against the current down-count.

All timing registers and the control register can only be written after an unlock. Software writes the key value to the key register, and that unlocks exactly one following write. Any write, to any address, uses up the unlock. A write to a protected register while the block is locked is dropped. A single enable bit gates all outputs. While it is clear, the outputs sit in the blanked state and both counters wait at their totals.

The usual programming for a mode is as follows. Each total is the sum of visible size, front margin, back margin and sync length, minus one. The sync window runs from the total down to total minus sync length. The active and blank windows run from total minus sync length minus the leading margin down to the trailing margin minus one. Visible sizes from 64×64 up to 1024×768 fit in the 16-bit count fields.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and directly after it, both counters and every register read as zero, the block is locked and disabled, pix_pos and line_pos are 0, hblank and vblank are 1, and hsync, vsync, active, pix_gate and line_gate are 0.
- R2: A write of exactly 0x000000AA to address 11 unlocks the block for one following write. That write takes effect if it goes to a protected address (0 to 10), and the block is locked again after it.
- R3: A write to a protected address while the block is locked changes no register and has no effect on any output.
- R4: The unlock is used up by the next write to any address other than a protected one as well: an address 12 to 15, or address 11 with a value other than 0xAA. The protected write after that is ignored.
- R5: While enabled, pix_pos steps down by one each clock. On the clock after it reads 0 it reloads the pixel total, which is bits [15:0] of address 5.
- R6: line_pos steps down by one only on a clock where pix_pos reloads from 0. When it is 0 at such a clock, it reloads the line total, which is bits [15:0] of address 0.
- R7: A window register holds start in bits [15:0] and stop in bits [31:16]. When start ≥ stop, the window covers counts c with stop < c ≤ start, and it is empty when start equals stop. When start < stop, the window wraps and covers c ≤ start or c > stop.
- R8: hsync is high while pix_pos is in the window at address 6. vsync is high while line_pos is in the window at address 1.
- R9: hblank is high while pix_pos is outside the window at address 8. vblank is high while line_pos is outside the window at address 3.
- R10: active is high while pix_pos is in the window at address 7 and line_pos is in the window at address 2. With standard programming it is high for exactly xres × yres clocks per frame.
- R11: pix_gate is high while pix_pos is in the window at address 9. line_gate is high while line_pos is in the window at address 4.
- R12: Bit 0 of address 10 enables the block. While it is clear, hsync, vsync, active and both gates are 0, both blanks are 1, and both counters hold their totals. Counting starts from the totals on the first clock after the enable is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| active | output | 1 | Active-video flag |
| pix_gate | output | 1 | Pixel-axis clock gate |
| line_gate | output | 1 | Line-axis clock gate |
| pix_pos | output | 16 | Current pixel down-count |
| line_pos | output | 16 | Current line down-count |

## Verification
The decoded outputs are combinational functions of the registered counters and window registers. A write accepted at a clock edge therefore shows up in the window outputs straight after that same edge. An enable change first moves the counters on the following edge, because the counters see the enable value from before the edge. The bench's reference model updates on every rising edge from the inputs applied before it, in the same order: counters first from the old register values, then the write. Every output is compared with the model at the falling edge, after all of that edge's registers have settled. Directed checks then count whole frames and lines at falling edges, starting from the cycle in which the enable write has landed.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 16;
    localparam int NUM_WIN = 4;

    // window index inside one axis; matches the address order of each axis
    localparam int WIN_SYNC  = 0;
    localparam int WIN_ACT   = 1;
    localparam int WIN_BLANK = 2;
    localparam int WIN_GATE  = 3;

    localparam logic [ADDR_W-1:0] ADDR_LINE_TOTAL = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_VWIN_BASE  = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_PIX_TOTAL  = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_HWIN_BASE  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_CTRL       = 4'd10;
    localparam logic [ADDR_W-1:0] ADDR_KEY        = 4'd11;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

    typedef struct packed {
        logic [FIELD_W-1:0] stop;
        logic [FIELD_W-1:0] start;
    } win_t;

    typedef struct packed {
        logic [FIELD_W-1:0]        total;
        win_t [NUM_WIN-1:0]        win;
    } axis_cfg_t;

    typedef struct packed {
        logic gate;
        logic blank_win;
        logic act;
        logic sync;
    } axis_sig_t;

    function automatic logic is_protected(logic [ADDR_W-1:0] a);
        return a <= ADDR_CTRL;
    endfunction

    // start is met first on the way down; stop is the first count outside
    function automatic logic in_window(logic [FIELD_W-1:0] c, win_t w);
        if (w.start >= w.stop)
            return (c <= w.start) && (c > w.stop);
        else
            return (c <= w.start) || (c > w.stop);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output axis_cfg_t         h_cfg,
    output axis_cfg_t         v_cfg,
    output logic              enable
);

    axis_cfg_t         h_q, v_q;
    logic              en_q;
    logic              unlocked_q;
    logic              key_wr;
    logic              prot_wr;
    logic [ADDR_W-1:0] vofs, hofs;

    always_comb begin
        key_wr  = wr_en && (wr_addr == ADDR_KEY);
        prot_wr = wr_en && is_protected(wr_addr);
        vofs    = wr_addr - ADDR_VWIN_BASE;
        hofs    = wr_addr - ADDR_HWIN_BASE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q        <= '0;
            v_q        <= '0;
            en_q       <= 1'b0;
            unlocked_q <= 1'b0;
        end else if (wr_en) begin
            if (key_wr) begin
                unlocked_q <= (wr_data == UNLOCK_KEY);
            end else begin
                unlocked_q <= 1'b0;
                if (prot_wr && unlocked_q) begin
                    if (wr_addr == ADDR_LINE_TOTAL)
                        v_q.total <= wr_data[FIELD_W-1:0];
                    else if (wr_addr < ADDR_PIX_TOTAL)
                        v_q.win[vofs[1:0]] <= win_t'(wr_data);
                    else if (wr_addr == ADDR_PIX_TOTAL)
                        h_q.total <= wr_data[FIELD_W-1:0];
                    else if (wr_addr < ADDR_CTRL)
                        h_q.win[hofs[1:0]] <= win_t'(wr_data);
                    else
                        en_q <= wr_data[0];
                end
            end
        end
    end

    assign h_cfg  = h_q;
    assign v_cfg  = v_q;
    assign enable = en_q;

    // R3: locked writes leave every register as it was
    p_locked_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        prot_wr && !unlocked_q |=> (h_q == $past(h_q)) && (v_q == $past(v_q)) && (en_q == $past(en_q)));

    // R2: the key arms the unlock
    p_key_arms_r2: assert property (@(posedge clk) disable iff (rst)
        key_wr && (wr_data == UNLOCK_KEY) |=> unlocked_q);

    // R4: any other write uses the unlock up
    p_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !key_wr |=> !unlocked_q);

endmodule

// File: rtl/rtg_downcnt.sv
module rtg_downcnt
    import rtg_pkg::*;
#(
    parameter int CNT_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = run && step && (cnt_q == '0);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= total;
        else if (step)
            cnt_q <= (cnt_q == '0) ? total : cnt_q - 1'b1;
    end

    // R5 (pixel axis) and R6 (line axis): reload after zero
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        run && step && (cnt_q == '0) |=> cnt_q == $past(total));

    // R5 and R6: single decrement otherwise
    p_decrement_r6: assert property (@(posedge clk) disable iff (rst)
        run && step && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R12: counter parked on its total while stopped
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == $past(total));

endmodule

// File: rtl/rtg_window.sv
module rtg_window
    import rtg_pkg::*;
(
    input  logic [FIELD_W-1:0] cnt,
    input  axis_cfg_t          cfg,
    output axis_sig_t          sig
);

    logic [NUM_WIN-1:0] hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign hit[g] = in_window(cnt, cfg.win[g]);
    end

    always_comb begin
        sig.sync      = hit[WIN_SYNC];
        sig.act       = hit[WIN_ACT];
        sig.blank_win = hit[WIN_BLANK];
        sig.gate      = hit[WIN_GATE];
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               hsync,
    output logic               vsync,
    output logic               hblank,
    output logic               vblank,
    output logic               active,
    output logic               pix_gate,
    output logic               line_gate,
    output logic [FIELD_W-1:0] pix_pos,
    output logic [FIELD_W-1:0] line_pos
);

    axis_cfg_t          h_cfg, v_cfg;
    logic               enable;
    logic [FIELD_W-1:0] hcnt, vcnt;
    logic               pix_wrap, line_wrap;
    axis_sig_t          hs, vs;

    rtg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .h_cfg   (h_cfg),
        .v_cfg   (v_cfg),
        .enable  (enable)
    );

    rtg_downcnt #(.CNT_W(FIELD_W)) u_pix_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (enable),
        .step  (1'b1),
        .total (h_cfg.total),
        .cnt   (hcnt),
        .wrap  (pix_wrap)
    );

    rtg_downcnt #(.CNT_W(FIELD_W)) u_line_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (enable),
        .step  (pix_wrap),
        .total (v_cfg.total),
        .cnt   (vcnt),
        .wrap  (line_wrap)
    );

    rtg_window u_hwin (.cnt(hcnt), .cfg(h_cfg), .sig(hs));
    rtg_window u_vwin (.cnt(vcnt), .cfg(v_cfg), .sig(vs));

    always_comb begin
        hsync     = enable && hs.sync;
        vsync     = enable && vs.sync;
        hblank    = !enable || !hs.blank_win;
        vblank    = !enable || !vs.blank_win;
        active    = enable && hs.act && vs.act;
        pix_gate  = enable && hs.gate;
        line_gate = enable && vs.gate;
        pix_pos   = hcnt;
        line_pos  = vcnt;
    end

    // R6: a frame wraps only at the last pixel of the last line
    p_frame_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        line_wrap |-> (pix_pos == '0) && (line_pos == '0));

    // R12: disabled outputs sit in the blanked state
    p_blanked_off_r12: assert property (@(posedge clk) disable iff (rst)
        !enable |-> hblank && vblank && !active && !hsync && !vsync && !pix_gate && !line_gate);

endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    // mode under test
    localparam int XRES = 64, HBACK = 4, HFRONT = 3, HSYNC_LEN = 5;
    localparam int YRES = 64, VBACK = 2, VFRONT = 3, VSYNC_LEN = 2;
    localparam int HT = XRES + HBACK + HFRONT + HSYNC_LEN - 1;
    localparam int VT = YRES + VBACK + VFRONT + VSYNC_LEN - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, hblank, vblank, active, pix_gate, line_gate;
    logic [15:0] pix_pos, line_pos;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit model_live = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .active(active), .pix_gate(pix_gate), .line_gate(line_gate),
        .pix_pos(pix_pos), .line_pos(line_pos)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [16];
    bit          m_unl;
    int          hc, vc;

    function automatic bit win(int c, logic [31:0] r);
        int s = int'(r[15:0]);
        int p = int'(r[31:16]);
        if (s >= p) return (c <= s) && (c > p);
        return (c <= s) || (c > p);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            foreach (m_reg[i]) m_reg[i] = '0;
            m_unl = 0; hc = 0; vc = 0;
        end else begin
            int ht, vt;
            ht = int'(m_reg[5][15:0]);
            vt = int'(m_reg[0][15:0]);
            if (!m_reg[10][0]) begin
                hc = ht; vc = vt;
            end else if (hc == 0) begin
                hc = ht;
                vc = (vc == 0) ? vt : vc - 1;
            end else begin
                hc = hc - 1;
            end
            if (wr_en) begin
                if (wr_addr == 4'd11) m_unl = (wr_data == 32'hAA);
                else begin
                    if (m_unl && wr_addr <= 4'd10) m_reg[wr_addr] = wr_data;
                    m_unl = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_live && !rst) begin
            bit en;
            en = m_reg[10][0];
            chk("R5", "pix_pos", int'(pix_pos), hc);
            chk("R6", "line_pos", int'(line_pos), vc);
            chk("R8", "hsync", int'(hsync), int'(en && win(hc, m_reg[6])));
            chk("R8", "vsync", int'(vsync), int'(en && win(vc, m_reg[1])));
            chk("R9", "hblank", int'(hblank), int'(!en || !win(hc, m_reg[8])));
            chk("R9", "vblank", int'(vblank), int'(!en || !win(vc, m_reg[3])));
            chk("R10", "active", int'(active), int'(en && win(hc, m_reg[7]) && win(vc, m_reg[2])));
            chk("R11", "pix_gate", int'(pix_gate), int'(en && win(hc, m_reg[9])));
            chk("R11", "line_gate", int'(line_gate), int'(en && win(vc, m_reg[4])));
        end
        if (cycles > WATCHDOG) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pw(int a, logic [31:0] d);
        wr(11, 32'hAA);
        wr(a, d);
    endtask

    function automatic logic [31:0] pack(int start, int stop);
        return {16'(stop), 16'(start)};
    endfunction

    initial begin
        int n_act, n_hs, n_vs, n_hb, n_vb, n_pg, n_lg;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_live = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "pix_pos after reset", int'(pix_pos), 0);
        chk("R1", "line_pos after reset", int'(line_pos), 0);
        chk("R1", "hblank after reset", int'(hblank), 1);
        chk("R1", "vblank after reset", int'(vblank), 1);
        chk("R1", "active after reset", int'(active), 0);

        // R3: enable without key is dropped
        wr(10, 32'h1);
        @(negedge clk);
        chk("R3", "hblank after locked enable", int'(hblank), 1);

        // program standard mode
        pw(0, VT);
        pw(1, pack(VT, VT - VSYNC_LEN));
        pw(2, pack(VT - VSYNC_LEN - VBACK, VFRONT - 1));
        pw(3, pack(VT - VSYNC_LEN - VBACK, VFRONT - 1));
        pw(4, pack(VT, VT + 1));
        pw(5, HT);
        pw(6, pack(HT, HT - HSYNC_LEN));
        pw(7, pack(HT - HSYNC_LEN - HBACK, HFRONT - 1));
        pw(8, pack(HT - HSYNC_LEN - HBACK, HFRONT - 1));
        pw(9, pack(HT, HT));
        pw(10, 32'h1);

        // R12: counting begins at the totals
        chk("R12", "pix_pos at enable", int'(pix_pos), HT);
        chk("R12", "line_pos at enable", int'(line_pos), VT);

        n_act = 0; n_hs = 0; n_vs = 0; n_hb = 0; n_vb = 0; n_pg = 0; n_lg = 0;
        for (int i = 0; i < (HT + 1) * (VT + 1); i++) begin
            n_act += int'(active); n_hs += int'(hsync); n_vs += int'(vsync);
            n_hb += int'(hblank); n_vb += int'(vblank);
            n_pg += int'(pix_gate); n_lg += int'(line_gate);
            @(negedge clk);
        end
        chk("R10", "active clocks per frame", n_act, XRES * YRES);
        chk("R8", "hsync clocks per frame", n_hs, HSYNC_LEN * (VT + 1));
        chk("R8", "vsync clocks per frame", n_vs, VSYNC_LEN * (HT + 1));
        chk("R9", "hblank clocks per frame", n_hb, (HT + 1 - XRES) * (VT + 1));
        chk("R9", "vblank clocks per frame", n_vb, (VT + 1 - YRES) * (HT + 1));
        chk("R7", "empty pixel gate window", n_pg, 0);
        chk("R11", "wrapping line gate window", n_lg, (HT + 1) * (VT + 1));
        chk("R5", "pixel counter back at total", int'(pix_pos), HT);
        chk("R6", "line counter back at total", int'(line_pos), VT);

        // R7: ordinary and wrapping windows on the pixel gate
        pw(9, pack(10, 5));
        n_pg = 0;
        for (int i = 0; i < HT + 1; i++) begin n_pg += int'(pix_gate); @(negedge clk); end
        chk("R7", "ordinary window length", n_pg, 5);
        pw(9, pack(5, 10));
        n_pg = 0;
        for (int i = 0; i < HT + 1; i++) begin n_pg += int'(pix_gate); @(negedge clk); end
        chk("R7", "wrapping window length", n_pg, (HT + 1) - 5);

        // R4: unlock spent on unprotected address and on a wrong key value
        wr(11, 32'hAA); wr(13, 32'h0); wr(10, 32'h0);
        @(negedge clk);
        chk("R4", "line_gate after spent unlock (addr 13)", int'(line_gate), 1);
        wr(11, 32'hAA); wr(11, 32'h55); wr(10, 32'h0);
        @(negedge clk);
        chk("R4", "line_gate after spent unlock (bad key)", int'(line_gate), 1);

        // R2: one unlocked write lands, the next does not
        pw(10, 32'h0);
        chk("R2", "line_gate after unlocked disable", int'(line_gate), 0);
        @(negedge clk);
        chk("R12", "pix_pos held at total", int'(pix_pos), HT);
        wr(10, 32'h1);
        @(negedge clk);
        chk("R2", "relocked after one write", int'(line_gate), 0);
        chk("R12", "hblank held while disabled", int'(hblank), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule